// File: doc/BRIEF.md
# Bridge Configuration Register Controller

This block holds the bridge-specific registers of a type-1 configuration header: the primary, secondary and subordinate bus numbers, the secondary latency timer, the I/O, memory and prefetchable base/limit registers with their upper extensions, the command word and the bridge control word. A configuration agent writes it one dword at a time with per-byte lane enables, and reads it through a combinational read port indexed by dword. Identification, class code, header type and both status words are constant fields that can be read.

Downstream, window decode logic must rebuild its forwarding ranges whenever one of the registers it uses changes. The block gives it a one-cycle remap strobe after any write whose enabled bytes fall on one of those registers. A one-cycle secondary bus reset pulse goes to the secondary side when software sets the reset bit of bridge control. Two presets are available. Reset clears everything to zero. A separate forwarding-off request leaves every window empty.

Top module: `bridge_cfg_regs`

## Requirements
- R1: After reset these all read zero: the bus numbers and latency timer (dword 6), the address bits of every base and limit register (dwords 7 to 9), the prefetchable upper registers (dwords 10 and 11), the I/O upper registers (dword 12), the command word (dword 1 bits 15:0) and bridge control (dword 15 bits 31:16).
- R2: Bits 3:0 of the I/O base and I/O limit bytes (dword 7 bits 3:0 and 11:8) read 1 when 32-bit I/O is configured, and 0 otherwise. Bits 3:0 of the prefetchable base and limit words (dword 9 bits 3:0 and 19:16) read 1 when 64-bit prefetchable is configured, and 0 otherwise. Writes do not change any of these bits.
- R3: A write changes only the byte lanes whose enable bit is set. Enable bit i covers data bits 8i+7 to 8i.
- R4: The remap strobe is high in the cycle after a write when any enabled byte lies in one of these byte offsets: 0x04 to 0x05, 0x1C to 0x1D, 0x20 to 0x33, or 0x3E to 0x3F. After a write that touches none of them, the strobe stays low.
- R5: The secondary reset pulse is high for one cycle, in the cycle after a write that takes bridge control bit 6 (dword 15, data bit 22, lane 2) from 0 to 1. A write that leaves the bit at 1, or that clears it, gives no pulse.
- R6: A forwarding-off request does four things: it sets the address bits of the I/O, memory and prefetchable base registers to all ones, clears those of the three limit registers, zeroes both prefetchable upper registers, and raises the remap strobe in the next cycle. A write in the same cycle as the request is discarded.
- R7: Dword 2 reads class code 0x060400 in bits 31:8. Header type byte 0x0E (dword 3 bits 23:16) reads 0x01, with bit 7 set when the device is configured as multi-function.
- R8: The primary status word (dword 1 bits 31:16) and the secondary status word (dword 7 bits 31:16) both read 0x00A0, which marks 66 MHz capable and fast back-to-back capable. Writes to them have no effect.
- R9: Only the command bits in mask 0x0547 and the bridge control bits 11:0 can be written. All other bits of those words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write request this cycle |
| wrIdx | input | 4 | Dword index of the write (byte offset / 4) |
| wrBe | input | 4 | Byte lane enables of the write |
| wrData | input | 32 | Write data |
| fwdOff | input | 1 | Forwarding-off preset request |
| rdIdx | input | 4 | Dword index to read |
| rdData | output | 32 | Read data for rdIdx, combinational |
| remapPulse | output | 1 | One-cycle strobe: window registers may have changed |
| secResetPulse | output | 1 | One-cycle secondary bus reset request |

## Verification
Four properties are checked on every cycle: every remap strobe has a write or preset behind it; every secondary reset pulse coincides with a 0-to-1 change of the stored reset bit and comes with a remap strobe; the register state right after reset is all zero; and the state right after a preset is the empty-window pattern. Only the bench scenarios show the exact byte ranges that do or do not raise the strobe (0x33 versus 0x34, and lanes 0x3C to 0x3D against 0x3E to 0x3F), the byte-lane merging, the read-only type nibbles and status words, the writable-bit masks, and that a write is dropped when a preset arrives in the same cycle.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;
  localparam int HDR_DWORDS = 16;
  localparam int IDX_W      = $clog2(HDR_DWORDS);
  localparam int HDR_BYTES  = HDR_DWORDS * 4;

  // dword positions inside the type-1 header
  localparam int DW_CMD   = 1;
  localparam int DW_CLASS = 2;
  localparam int DW_HTYPE = 3;
  localparam int DW_BUS   = 6;
  localparam int DW_IO    = 7;
  localparam int DW_MEM   = 8;
  localparam int DW_PREF  = 9;
  localparam int DW_PBUP  = 10;
  localparam int DW_PLUP  = 11;
  localparam int DW_IOUP  = 12;
  localparam int DW_CTL   = 15;

  localparam logic [15:0] STATUS_CAPS = 16'h00A0;
  localparam logic [23:0] CLASS_P2P   = 24'h060400;
  localparam int          CTL_RST_BIT = 6;

  typedef struct packed {
    logic [HDR_DWORDS-1:0] dwHit;
    logic [3:0]            laneEn;
    logic                  presetOff;
  } cfgStrobe_t;
endpackage

// File: rtl/bcfg_ctrl.sv
module bcfg_ctrl
  import bcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [3:0]       wrBe,
  input  logic [31:0]      wrData,
  input  logic             fwdOff,
  input  logic             busRstBit,
  output cfgStrobe_t       strobe,
  output logic             remapPulse,
  output logic             secResetPulse
);
  function automatic logic [HDR_BYTES-1:0] winBytes();
    logic [HDR_BYTES-1:0] m;
    for (int b = 0; b < HDR_BYTES; b++) begin
      m[b] = (b >= 4  && b <= 5)  || (b >= 28 && b <= 29) ||
             (b >= 32 && b <= 51) || (b >= 62 && b <= 63);
    end
    return m;
  endfunction

  localparam logic [HDR_BYTES-1:0] WIN_MASK = winBytes();
  localparam int CTL_DATA_BIT = 16 + CTL_RST_BIT;

  logic [HDR_BYTES-1:0] touched;
  logic                 writeLive;
  logic                 remapNext;
  logic                 rstNext;

  assign writeLive = wrEn && !fwdOff;
  assign touched   = HDR_BYTES'(wrBe) << {wrIdx, 2'b00};

  always_comb begin
    strobe.dwHit     = '0;
    strobe.laneEn    = wrBe;
    strobe.presetOff = fwdOff;
    if (writeLive) strobe.dwHit[wrIdx] = 1'b1;
  end

  assign remapNext = (writeLive && |(touched & WIN_MASK)) || fwdOff;
  assign rstNext   = writeLive && (wrIdx == IDX_W'(DW_CTL)) && wrBe[2] &&
                     wrData[CTL_DATA_BIT] && !busRstBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      remapPulse    <= 1'b0;
      secResetPulse <= 1'b0;
    end else begin
      remapPulse    <= remapNext;
      secResetPulse <= rstNext;
    end
  end

  p_remap_cause_r4: assert property (@(posedge clk) disable iff (rst)
    remapPulse |-> (!$past(rst) && $past(wrEn || fwdOff)));

  p_secrst_edge_r5: assert property (@(posedge clk) disable iff (rst)
    secResetPulse |-> (busRstBit && !$past(busRstBit)));

  p_secrst_remap_r5: assert property (@(posedge clk) disable iff (rst)
    secResetPulse |-> remapPulse);
endmodule

// File: rtl/bcfg_datapath.sv
module bcfg_datapath
  import bcfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID  = 16'h0B01,
  parameter logic [7:0]  REV_ID     = 8'h00,
  parameter bit          MULTI_FUNC = 1'b0,
  parameter bit          IO32       = 1'b1,
  parameter bit          PREF64     = 1'b1,
  parameter logic [15:0] CMD_WMASK  = 16'h0547,
  parameter logic [15:0] CTL_WMASK  = 16'h0FFF
)(
  input  logic             clk,
  input  logic             rst,
  input  cfgStrobe_t       strobe,
  input  logic [31:0]      wrData,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [31:0]      rdData,
  output logic             busRstBit
);
  localparam logic [3:0] IO_TYPE   = IO32   ? 4'h1 : 4'h0;
  localparam logic [3:0] PREF_TYPE = PREF64 ? 4'h1 : 4'h0;
  localparam logic [7:0] HDR_TYPE  = {MULTI_FUNC, 7'h01};

  logic [15:0] cmdReg, brCtl;
  logic [7:0]  priBus, secBus, subBus, secLat;
  logic [3:0]  ioBaseA, ioLimA;
  logic [11:0] memBaseA, memLimA, prefBaseA, prefLimA;
  logic [31:0] prefBaseUp, prefLimUp;
  logic [15:0] ioBaseUp, ioLimUp;
  logic [3:0]  be;
  logic [15:0] hit;

  assign be  = strobe.laneEn;
  assign hit = strobe.dwHit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdReg <= '0; brCtl <= '0;
      priBus <= '0; secBus <= '0; subBus <= '0; secLat <= '0;
      ioBaseA <= '0; ioLimA <= '0;
      memBaseA <= '0; memLimA <= '0; prefBaseA <= '0; prefLimA <= '0;
      prefBaseUp <= '0; prefLimUp <= '0; ioBaseUp <= '0; ioLimUp <= '0;
    end else if (strobe.presetOff) begin
      ioBaseA    <= '1; ioLimA    <= '0;
      memBaseA   <= '1; memLimA   <= '0;
      prefBaseA  <= '1; prefLimA  <= '0;
      prefBaseUp <= '0; prefLimUp <= '0;
    end else begin
      if (hit[DW_CMD]) begin
        if (be[0]) cmdReg[7:0]  <= wrData[7:0]  & CMD_WMASK[7:0];
        if (be[1]) cmdReg[15:8] <= wrData[15:8] & CMD_WMASK[15:8];
      end
      if (hit[DW_BUS]) begin
        if (be[0]) priBus <= wrData[7:0];
        if (be[1]) secBus <= wrData[15:8];
        if (be[2]) subBus <= wrData[23:16];
        if (be[3]) secLat <= wrData[31:24];
      end
      if (hit[DW_IO]) begin
        if (be[0]) ioBaseA <= wrData[7:4];
        if (be[1]) ioLimA  <= wrData[15:12];
      end
      if (hit[DW_MEM]) begin
        if (be[0]) memBaseA[3:0]  <= wrData[7:4];
        if (be[1]) memBaseA[11:4] <= wrData[15:8];
        if (be[2]) memLimA[3:0]   <= wrData[23:20];
        if (be[3]) memLimA[11:4]  <= wrData[31:24];
      end
      if (hit[DW_PREF]) begin
        if (be[0]) prefBaseA[3:0]  <= wrData[7:4];
        if (be[1]) prefBaseA[11:4] <= wrData[15:8];
        if (be[2]) prefLimA[3:0]   <= wrData[23:20];
        if (be[3]) prefLimA[11:4]  <= wrData[31:24];
      end
      if (PREF64 && hit[DW_PBUP]) begin
        for (int i = 0; i < 4; i++)
          if (be[i]) prefBaseUp[i*8 +: 8] <= wrData[i*8 +: 8];
      end
      if (PREF64 && hit[DW_PLUP]) begin
        for (int i = 0; i < 4; i++)
          if (be[i]) prefLimUp[i*8 +: 8] <= wrData[i*8 +: 8];
      end
      if (IO32 && hit[DW_IOUP]) begin
        if (be[0]) ioBaseUp[7:0]  <= wrData[7:0];
        if (be[1]) ioBaseUp[15:8] <= wrData[15:8];
        if (be[2]) ioLimUp[7:0]   <= wrData[23:16];
        if (be[3]) ioLimUp[15:8]  <= wrData[31:24];
      end
      if (hit[DW_CTL]) begin
        if (be[2]) brCtl[7:0]  <= wrData[23:16] & CTL_WMASK[7:0];
        if (be[3]) brCtl[15:8] <= wrData[31:24] & CTL_WMASK[15:8];
      end
    end
  end

  assign busRstBit = brCtl[CTL_RST_BIT];

  always_comb begin
    case (rdIdx)
      4'd0:              rdData = {DEVICE_ID, VENDOR_ID};
      IDX_W'(DW_CMD):    rdData = {STATUS_CAPS, cmdReg};
      IDX_W'(DW_CLASS):  rdData = {CLASS_P2P, REV_ID};
      IDX_W'(DW_HTYPE):  rdData = {8'h00, HDR_TYPE, 16'h0000};
      IDX_W'(DW_BUS):    rdData = {secLat, subBus, secBus, priBus};
      IDX_W'(DW_IO):     rdData = {STATUS_CAPS, ioLimA, IO_TYPE, ioBaseA, IO_TYPE};
      IDX_W'(DW_MEM):    rdData = {memLimA, 4'h0, memBaseA, 4'h0};
      IDX_W'(DW_PREF):   rdData = {prefLimA, PREF_TYPE, prefBaseA, PREF_TYPE};
      IDX_W'(DW_PBUP):   rdData = prefBaseUp;
      IDX_W'(DW_PLUP):   rdData = prefLimUp;
      IDX_W'(DW_IOUP):   rdData = {ioLimUp, ioBaseUp};
      IDX_W'(DW_CTL):    rdData = {brCtl, 16'h0000};
      default:           rdData = 32'h0;
    endcase
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cmdReg == 0 && brCtl == 0 && priBus == 0 && secBus == 0 &&
                    subBus == 0 && secLat == 0 && ioBaseA == 0 && ioLimA == 0 &&
                    memBaseA == 0 && memLimA == 0 && prefBaseA == 0 &&
                    prefLimA == 0 && prefBaseUp == 0 && prefLimUp == 0));

  p_preset_empty_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(strobe.presetOff) && !$past(rst)) |->
      (ioBaseA == 4'hF && ioLimA == 0 && memBaseA == 12'hFFF && memLimA == 0 &&
       prefBaseA == 12'hFFF && prefLimA == 0 && prefBaseUp == 0 && prefLimUp == 0));
endmodule

// File: rtl/bridge_cfg_regs.sv
module bridge_cfg_regs
  import bcfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID  = 16'h0B01,
  parameter logic [7:0]  REV_ID     = 8'h00,
  parameter bit          MULTI_FUNC = 1'b0,
  parameter bit          IO32       = 1'b1,
  parameter bit          PREF64     = 1'b1,
  parameter logic [15:0] CMD_WMASK  = 16'h0547,
  parameter logic [15:0] CTL_WMASK  = 16'h0FFF
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [3:0]  wrIdx,
  input  logic [3:0]  wrBe,
  input  logic [31:0] wrData,
  input  logic        fwdOff,
  input  logic [3:0]  rdIdx,
  output logic [31:0] rdData,
  output logic        remapPulse,
  output logic        secResetPulse
);
  cfgStrobe_t strobe;
  logic       busRstBit;

  bcfg_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrIdx(wrIdx), .wrBe(wrBe),
    .wrData(wrData), .fwdOff(fwdOff), .busRstBit(busRstBit),
    .strobe(strobe), .remapPulse(remapPulse), .secResetPulse(secResetPulse)
  );

  bcfg_datapath #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REV_ID(REV_ID),
    .MULTI_FUNC(MULTI_FUNC), .IO32(IO32), .PREF64(PREF64),
    .CMD_WMASK(CMD_WMASK), .CTL_WMASK(CTL_WMASK)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(wrData),
    .rdIdx(rdIdx), .rdData(rdData), .busRstBit(busRstBit)
  );
endmodule

// File: tb/bridge_cfg_regs_bench.sv
`timescale 1ns/1ps
module bridge_cfg_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [3:0]  wrIdx = '0;
  logic [3:0]  wrBe = '0;
  logic [31:0] wrData = '0;
  logic        fwdOff = 1'b0;
  logic [3:0]  rdIdx = '0;
  logic [31:0] rdData;
  logic        remapPulse, secResetPulse;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bridge_cfg_regs #(.MULTI_FUNC(1'b1)) u_bridge_cfg_regs (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrIdx(wrIdx), .wrBe(wrBe),
    .wrData(wrData), .fwdOff(fwdOff), .rdIdx(rdIdx), .rdData(rdData),
    .remapPulse(remapPulse), .secResetPulse(secResetPulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rdChk(input string req, input logic [3:0] idx, input logic [31:0] exp);
    rdIdx = idx;
    #0.5;
    chk(req, rdData, exp);
  endtask

  // write one dword; after it, check both pulses in the following cycle
  task automatic wr(input string req, input logic [3:0] idx, input logic [3:0] be,
                    input logic [31:0] d, input logic expRemap, input logic expRst);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrBe = be; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrBe = '0;
    chk({req, " remap"}, 32'(remapPulse), 32'(expRemap));
    chk({req, " secrst"}, 32'(secResetPulse), 32'(expRst));
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset_state();
    doReset();
    rdChk("R1 bus", 4'd6, 32'h0);
    rdChk("R1 io", 4'd7, 32'h00A0_0101);
    rdChk("R1 mem", 4'd8, 32'h0);
    rdChk("R1 pref", 4'd9, 32'h0001_0001);
    rdChk("R1 pbup", 4'd10, 32'h0);
    rdChk("R1 plup", 4'd11, 32'h0);
    rdChk("R1 ioup", 4'd12, 32'h0);
    rdChk("R1 ctl", 4'd15, 32'h0);
    rdChk("R1 cmd", 4'd1, 32'h00A0_0000);
    chk("R1 remap idle", 32'(remapPulse), 0);
  endtask

  task automatic t_constants();
    rdChk("R7 class", 4'd2, 32'h0604_0000);
    rdChk("R7 htype", 4'd3, 32'h0081_0000);
  endtask

  task automatic t_bus_lanes();
    wr("R4 bus no remap", 4'd6, 4'hF, 32'h4005_0301, 1'b0, 1'b0);
    rdChk("R3 bus full", 4'd6, 32'h4005_0301);
    wr("R3 bus lane1", 4'd6, 4'h2, 32'hFFFF_FFFF, 1'b0, 1'b0);
    rdChk("R3 bus lane1 only", 4'd6, 32'h4005_FF01);
  endtask

  task automatic t_windows();
    wr("R4 io", 4'd7, 4'hF, 32'hFFFF_FFFF, 1'b1, 1'b0);
    chk("R4 one cycle", 32'(remapPulse), 1);
    @(negedge clk);
    chk("R4 strobe drops", 32'(remapPulse), 0);
    rdChk("R2 R8 io types status", 4'd7, 32'h00A0_F1F1);
    wr("R4 mem", 4'd8, 4'hF, 32'h1234_5678, 1'b1, 1'b0);
    rdChk("R3 mem", 4'd8, 32'h1230_5670);
    wr("R4 pref", 4'd9, 4'hF, 32'h0000_0000, 1'b1, 1'b0);
    rdChk("R2 pref type kept", 4'd9, 32'h0001_0001);
    wr("R4 pbup", 4'd10, 4'hF, 32'hDEAD_BEEF, 1'b1, 1'b0);
    rdChk("R3 pbup", 4'd10, 32'hDEAD_BEEF);
    wr("R4 plup", 4'd11, 4'hF, 32'h0000_00F0, 1'b1, 1'b0);
    wr("R4 span end 0x33", 4'd12, 4'h8, 32'hAB00_0000, 1'b1, 1'b0);
    wr("R4 ioup", 4'd12, 4'h7, 32'h00CD_1234, 1'b1, 1'b0);
    rdChk("R3 ioup", 4'd12, 32'hABCD_1234);
    wr("R4 past span 0x34", 4'd13, 4'hF, 32'hFFFF_FFFF, 1'b0, 1'b0);
  endtask

  task automatic t_command();
    wr("R4 cmd", 4'd1, 4'hF, 32'hFFFF_FFFF, 1'b1, 1'b0);
    rdChk("R8 R9 cmd mask", 4'd1, 32'h00A0_0547);
    wr("R4 status lanes only", 4'd1, 4'hC, 32'h0000_0000, 1'b0, 1'b0);
    rdChk("R8 status ro", 4'd1, 32'h00A0_0547);
  endtask

  task automatic t_ctl();
    wr("R5 set", 4'd15, 4'h4, 32'h0040_0000, 1'b1, 1'b1);
    rdChk("R5 ctl read", 4'd15, 32'h0040_0000);
    wr("R5 hold", 4'd15, 4'h4, 32'h0040_0000, 1'b1, 1'b0);
    wr("R5 clear", 4'd15, 4'h4, 32'h0000_0000, 1'b1, 1'b0);
    wr("R4 lanes 3C-3D", 4'd15, 4'h3, 32'hFFFF_FFFF, 1'b0, 1'b0);
    wr("R5 R9 full", 4'd15, 4'hF, 32'hFFFF_FFFF, 1'b1, 1'b1);
    rdChk("R9 ctl mask", 4'd15, 32'h0FFF_0000);
  endtask

  task automatic t_preset();
    @(negedge clk);
    fwdOff = 1'b1;
    wrEn = 1'b1; wrIdx = 4'd8; wrBe = 4'hF; wrData = 32'h5555_5555;
    @(negedge clk);
    fwdOff = 1'b0; wrEn = 1'b0; wrBe = '0;
    chk("R6 remap", 32'(remapPulse), 1);
    chk("R6 no secrst", 32'(secResetPulse), 0);
    rdChk("R6 io", 4'd7, 32'h00A0_01F1);
    rdChk("R6 mem write dropped", 4'd8, 32'h0000_FFF0);
    rdChk("R6 pref", 4'd9, 32'h0001_FFF1);
    rdChk("R6 pbup", 4'd10, 32'h0);
    rdChk("R6 plup", 4'd11, 32'h0);
    rdChk("R6 ioup kept", 4'd12, 32'hABCD_1234);
    rdChk("R6 ctl kept", 4'd15, 32'h0FFF_0000);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_constants();
    t_bus_lanes();
    t_windows();
    t_command();
    t_ctl();
    t_preset();
    t_reset_state();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule